// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit sits between operand decode and the load/store path of a processor pipeline. Each cycle it takes a decoded 3-bit addressing mode, the 16-bit constant carried in the instruction word and the values of up to two source registers. From these it produces either an immediate operand or a 32-bit effective memory address. It also raises two flags: one saying the operand is a literal, and one saying a memory access has to be started. Register-file reads and the memory access itself happen elsewhere.

Seven modes are decoded:
- register operand
- literal (immediate)
- absolute address
- register indirect
- register plus signed constant
- sum of two registers
- sum of two registers plus a signed constant

The eighth encoding is reserved. It raises an illegal-mode flag and forces the address to zero. All results are registered once, so they appear on the clock edge after the inputs are sampled. Address sums wrap silently modulo 2^32.

Top module: `eag_top`

## Requirements
- R1: A synchronous active-low reset clears every output to zero, whatever the inputs hold while reset is low.
- R2: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency), with a fresh result each cycle.
- R3: Mode 3'b000 (register operand) drives address 0, literal flag 0, memory flag 0, literal value 0 and illegal flag 0.
- R4: Mode 3'b001 (literal) drives the literal value as the 16-bit constant sign-extended to 32 bits, literal flag 1, memory flag 0 and address 0.
- R5: Mode 3'b010 (absolute) drives the address as the 16-bit constant zero-extended to 32 bits, memory flag 1 and literal flag 0.
- R6: Mode 3'b011 (indirect) drives the address equal to register A, memory flag 1.
- R7: Mode 3'b100 (indexed) drives the address as sign-extended constant plus register A, memory flag 1. Register B has no effect.
- R8: Mode 3'b101 (base plus index) drives the address as register A plus register B, memory flag 1. The constant has no effect.
- R9: Mode 3'b110 (base plus index plus offset) drives the address as sign-extended constant plus register A plus register B, memory flag 1.
- R10: Address sums wrap modulo 2^32, and no overflow or carry indication is produced.
- R11: Mode 3'b111 raises the illegal flag and drives address 0, memory flag 0, literal flag 0 and literal value 0. The illegal flag is 0 in every other mode.
- R12: The literal flag and the memory flag are never both 1. The literal value is 0 in every mode other than 3'b001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Decoded addressing mode |
| const_i | input | 16 | Constant field of the instruction |
| reg_a_i | input | 32 | First source register value (pointer or index) |
| reg_b_i | input | 32 | Second source register value (base) |
| eff_addr_o | output | 32 | Effective memory address, zero when no access |
| imm_flag_o | output | 1 | Operand is a literal |
| mem_flag_o | output | 1 | A memory access is required |
| imm_value_o | output | 32 | Sign-extended literal operand |
| illegal_o | output | 1 | Reserved mode encoding seen |

## Verification
All results come out of one register stage, so every output is due exactly one rising edge after the inputs that produce it. The bench changes inputs on the falling edge and checks the outputs on the next falling edge. By then exactly one capture edge has passed, so each check compares against the inputs driven one half-period before that edge. During reset the same timing applies, and the expected value is all zeros.

// File: rtl/eag_pkg.sv
// Package: shared encodings and control bundle for the effective address generator.
// Assumes a 3-bit mode code; code 7 is reserved.
package eag_pkg;

    typedef enum logic [2:0] {
        MODE_REG    = 3'd0,
        MODE_IMM    = 3'd1,
        MODE_ABS    = 3'd2,
        MODE_IND    = 3'd3,
        MODE_IDX    = 3'd4,
        MODE_BIDX   = 3'd5,
        MODE_BIDXC  = 3'd6,
        MODE_RSVD   = 3'd7
    } mode_e;

    // Per-mode steering of the operand/address datapath.
    typedef struct packed {
        logic use_const;    // constant enters the adder
        logic const_sext;   // constant is sign-extended (else zero-extended)
        logic use_ra;       // register A enters the adder
        logic use_rb;       // register B enters the adder
        logic is_imm;       // literal operand
        logic mem_acc;      // address is meaningful, access required
        logic illegal;      // reserved encoding
    } ctl_t;

endpackage

// File: rtl/eag_mode_decode.sv
// Module: eag_mode_decode
// Turns the 3-bit mode code into datapath steering bits.
// Assumes the code is already decoded from the instruction; purely combinational.
module eag_mode_decode
    import eag_pkg::*;
(
    input  logic [2:0] mode_i,
    output ctl_t       ctl_o
);

    // Map each mode to which terms are summed and which flags are raised.
    always_comb begin
        ctl_o = '0;
        unique case (mode_e'(mode_i))
            MODE_REG:   ctl_o = '0;
            MODE_IMM:   begin
                ctl_o.is_imm     = 1'b1;
            end
            MODE_ABS:   begin
                ctl_o.use_const  = 1'b1;
                ctl_o.mem_acc    = 1'b1;
            end
            MODE_IND:   begin
                ctl_o.use_ra     = 1'b1;
                ctl_o.mem_acc    = 1'b1;
            end
            MODE_IDX:   begin
                ctl_o.use_const  = 1'b1;
                ctl_o.const_sext = 1'b1;
                ctl_o.use_ra     = 1'b1;
                ctl_o.mem_acc    = 1'b1;
            end
            MODE_BIDX:  begin
                ctl_o.use_ra     = 1'b1;
                ctl_o.use_rb     = 1'b1;
                ctl_o.mem_acc    = 1'b1;
            end
            MODE_BIDXC: begin
                ctl_o.use_const  = 1'b1;
                ctl_o.const_sext = 1'b1;
                ctl_o.use_ra     = 1'b1;
                ctl_o.use_rb     = 1'b1;
                ctl_o.mem_acc    = 1'b1;
            end
            MODE_RSVD:  begin
                ctl_o.illegal    = 1'b1;
            end
            default:    ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/eag_addr_sum.sv
// Module: eag_addr_sum
// Gates the constant and both registers by the steering bits and adds them.
// Also forms the sign-extended literal. Sums wrap at ADDR_W bits; carries are dropped.
// Assumes ADDR_W > CONST_W.
module eag_addr_sum #(
    parameter int ADDR_W  = 32,
    parameter int CONST_W = 16
) (
    input  logic [CONST_W-1:0] const_i,
    input  logic [ADDR_W-1:0]  reg_a_i,
    input  logic [ADDR_W-1:0]  reg_b_i,
    input  logic               use_const_i,
    input  logic               const_sext_i,
    input  logic               use_ra_i,
    input  logic               use_rb_i,
    input  logic               is_imm_i,
    input  logic               mem_acc_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [ADDR_W-1:0]  imm_o
);

    localparam int EXT_W = ADDR_W - CONST_W;

    logic [ADDR_W-1:0] const_sx;
    logic [ADDR_W-1:0] const_zx;
    logic [ADDR_W-1:0] term_c;
    logic [ADDR_W-1:0] term_a;
    logic [ADDR_W-1:0] term_b;
    logic [ADDR_W-1:0] total;

    // Widen the constant both ways.
    always_comb begin
        const_sx = {{EXT_W{const_i[CONST_W-1]}}, const_i};
        const_zx = {{EXT_W{1'b0}}, const_i};
    end

    // Select which terms reach the adder; unused terms are forced to zero.
    always_comb begin
        term_c = use_const_i ? (const_sext_i ? const_sx : const_zx) : '0;
        term_a = use_ra_i ? reg_a_i : '0;
        term_b = use_rb_i ? reg_b_i : '0;
    end

    // Three-term modular sum.
    always_comb begin
        total = term_c + term_a + term_b;
    end

    // Qualify the outputs by mode class.
    always_comb begin
        addr_o = mem_acc_i ? total : '0;
        imm_o  = is_imm_i ? const_sx : '0;
    end

endmodule

// File: rtl/eag_out_stage.sv
// Module: eag_out_stage
// Output timing stage. When OUT_REG is set, results are captured on the rising edge
// and cleared by synchronous active-low reset. Otherwise they pass straight through.
module eag_out_stage #(
    parameter int ADDR_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [ADDR_W-1:0] imm_d,
    input  logic              imm_flag_d,
    input  logic              mem_flag_d,
    input  logic              illegal_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] imm_q,
    output logic              imm_flag_q,
    output logic              mem_flag_q,
    output logic              illegal_q
);

    generate
        if (OUT_REG) begin : g_reg
            // Capture one result per cycle; reset clears everything.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q     <= '0;
                    imm_q      <= '0;
                    imm_flag_q <= 1'b0;
                    mem_flag_q <= 1'b0;
                    illegal_q  <= 1'b0;
                end else begin
                    addr_q     <= addr_d;
                    imm_q      <= imm_d;
                    imm_flag_q <= imm_flag_d;
                    mem_flag_q <= mem_flag_d;
                    illegal_q  <= illegal_d;
                end
            end
        end else begin : g_comb
            // Pass-through variant for a combinational slot.
            always_comb begin
                addr_q     = addr_d;
                imm_q      = imm_d;
                imm_flag_q = imm_flag_d;
                mem_flag_q = mem_flag_d;
                illegal_q  = illegal_d;
            end
        end
    endgenerate

endmodule

// File: rtl/eag_top.sv
// Module: eag_top
// Effective address generator. It decodes the mode, sums the selected terms and
// registers the results. Assumes register values are already read and stable for the cycle.
module eag_top #(
    parameter int ADDR_W  = 32,
    parameter int CONST_W = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_i,
    input  logic [CONST_W-1:0] const_i,
    input  logic [ADDR_W-1:0]  reg_a_i,
    input  logic [ADDR_W-1:0]  reg_b_i,
    output logic [ADDR_W-1:0]  eff_addr_o,
    output logic               imm_flag_o,
    output logic               mem_flag_o,
    output logic [ADDR_W-1:0]  imm_value_o,
    output logic               illegal_o
);
    import eag_pkg::*;

    ctl_t              ctl;
    logic [ADDR_W-1:0] addr_c;
    logic [ADDR_W-1:0] imm_c;

    eag_mode_decode dec_i (
        .mode_i (mode_i),
        .ctl_o  (ctl)
    );

    eag_addr_sum #(
        .ADDR_W  (ADDR_W),
        .CONST_W (CONST_W)
    ) sum_i (
        .const_i      (const_i),
        .reg_a_i      (reg_a_i),
        .reg_b_i      (reg_b_i),
        .use_const_i  (ctl.use_const),
        .const_sext_i (ctl.const_sext),
        .use_ra_i     (ctl.use_ra),
        .use_rb_i     (ctl.use_rb),
        .is_imm_i     (ctl.is_imm),
        .mem_acc_i    (ctl.mem_acc),
        .addr_o       (addr_c),
        .imm_o        (imm_c)
    );

    eag_out_stage #(
        .ADDR_W  (ADDR_W),
        .OUT_REG (OUT_REG)
    ) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_d     (addr_c),
        .imm_d      (imm_c),
        .imm_flag_d (ctl.is_imm),
        .mem_flag_d (ctl.mem_acc),
        .illegal_d  (ctl.illegal),
        .addr_q     (eff_addr_o),
        .imm_q      (imm_value_o),
        .imm_flag_q (imm_flag_o),
        .mem_flag_q (mem_flag_o),
        .illegal_q  (illegal_o)
    );

endmodule

// File: rtl/eag_checker.sv
// Module: eag_checker
// Temporal properties of eag_top, relating sampled inputs to the outputs
// one edge later. Assumes the registered variant; it is bound to the top below.
module eag_checker #(
    parameter int ADDR_W  = 32,
    parameter int CONST_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         mode_i,
    input logic [CONST_W-1:0] const_i,
    input logic [ADDR_W-1:0]  reg_a_i,
    input logic [ADDR_W-1:0]  reg_b_i,
    input logic [ADDR_W-1:0]  eff_addr_o,
    input logic               imm_flag_o,
    input logic               mem_flag_o,
    input logic [ADDR_W-1:0]  imm_value_o,
    input logic               illegal_o
);

    localparam int EXT_W = ADDR_W - CONST_W;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (eff_addr_o == '0 && imm_value_o == '0 && !imm_flag_o && !mem_flag_o && !illegal_o));

    // R6
    indirect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_i == 3'd3) |=> (eff_addr_o == $past(reg_a_i) && mem_flag_o));

    // R7
    index_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_i == 3'd4) |=>
        (eff_addr_o == $past({{EXT_W{const_i[CONST_W-1]}}, const_i} + reg_a_i)));

    // R9
    base_index_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_i == 3'd6) |=>
        (eff_addr_o == $past({{EXT_W{const_i[CONST_W-1]}}, const_i} + reg_a_i + reg_b_i)));

    // R11
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (eff_addr_o == '0 && !mem_flag_o && !imm_flag_o));

    // R11
    illegal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (illegal_o == ($past(mode_i) == 3'd7)));

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(imm_flag_o && mem_flag_o));

    // R2
    output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $stable(mode_i) && $stable(const_i) && $stable(reg_a_i) && $stable(reg_b_i) && $past(rst_n))
        |=> $stable(eff_addr_o));

endmodule

bind eag_top eag_checker #(
    .ADDR_W  (ADDR_W),
    .CONST_W (CONST_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .const_i     (const_i),
    .reg_a_i     (reg_a_i),
    .reg_b_i     (reg_b_i),
    .eff_addr_o  (eff_addr_o),
    .imm_flag_o  (imm_flag_o),
    .mem_flag_o  (mem_flag_o),
    .imm_value_o (imm_value_o),
    .illegal_o   (illegal_o)
);

// File: tb/eag_top_tb.sv
// Bench for eag_top: directed corner cases plus seeded random stimulus.
// Expected values come from bench functions.
module eag_top_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  AW = 32;
    localparam int  CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [CW-1:0] cval = '0;
    logic [AW-1:0] ra = '0;
    logic [AW-1:0] rb = '0;
    logic [AW-1:0] eff_addr;
    logic          imm_flag;
    logic          mem_flag;
    logic [AW-1:0] imm_value;
    logic          illegal;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .const_i     (cval),
        .reg_a_i     (ra),
        .reg_b_i     (rb),
        .eff_addr_o  (eff_addr),
        .imm_flag_o  (imm_flag),
        .mem_flag_o  (mem_flag),
        .imm_value_o (imm_value),
        .illegal_o   (illegal)
    );

    function automatic logic [AW-1:0] sx(input logic [CW-1:0] c);
        return {{(AW-CW){c[CW-1]}}, c};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [2:0] m, input logic [CW-1:0] c,
                                               input logic [AW-1:0] a, input logic [AW-1:0] b);
        case (m)
            3'd2:    return {{(AW-CW){1'b0}}, c};
            3'd3:    return a;
            3'd4:    return sx(c) + a;
            3'd5:    return a + b;
            3'd6:    return sx(c) + a + b;
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Drive on a falling edge; check on the next falling edge (one capture edge later, R2).
    task automatic run(input logic [2:0] m, input logic [CW-1:0] c,
                       input logic [AW-1:0] a, input logic [AW-1:0] b, input string extra);
        string r;
        mode = m; cval = c; ra = a; rb = b;
        @(negedge clk);
        r = {req_of(m), extra};
        chk(r, "addr", eff_addr, exp_addr(m, c, a, b));
        chk(r, "imm_value", imm_value, (m == 3'd1) ? sx(c) : '0);
        chk(r, "imm_flag", {31'd0, imm_flag}, {31'd0, m == 3'd1});
        chk(r, "mem_flag", {31'd0, mem_flag}, {31'd0, (m >= 3'd2 && m <= 3'd6)});
        chk({r, "/R11"}, "illegal", {31'd0, illegal}, {31'd0, m == 3'd7});
        chk({r, "/R12"}, "flag_excl", {31'd0, imm_flag & mem_flag}, '0);
    endtask

    task automatic chk_zero(input string req);
        chk(req, "addr", eff_addr, '0);
        chk(req, "imm_value", imm_value, '0);
        chk(req, "flags", {29'd0, imm_flag, mem_flag, illegal}, '0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++; n_checks++;
                $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset holds outputs at zero with busy inputs
        mode = 3'd1; cval = 16'h8001; ra = 32'hDEAD_BEEF; rb = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk_zero("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Directed mode cases
        run(3'd0, 16'h1234, 32'hAAAA_0000, 32'h5555, "");
        run(3'd1, 16'hFFFE, 32'h1, 32'h2, "");
        run(3'd1, 16'h7FFF, 32'h1, 32'h2, "");
        run(3'd2, 16'h8000, 32'hFFFF_FFFF, 32'h10, "");
        run(3'd3, 16'h0040, 32'h0000_1000, 32'h99, "");
        run(3'd4, 16'h0010, 32'h0000_2000, 32'hFFFF_0000, " R7 Bignored");
        run(3'd4, 16'hFFF0, 32'h0000_2000, 32'h0, " neg offset");
        run(3'd5, 16'h7777, 32'h0000_3000, 32'h0000_0400, " R8 Cignored");
        run(3'd6, 16'h000C, 32'h0000_4000, 32'h0000_0100, "");
        // R10: wrap without any overflow indication
        run(3'd4, 16'h0001, 32'hFFFF_FFFF, 32'h0, " R10 wrap");
        run(3'd5, 16'h0000, 32'h8000_0000, 32'h8000_0000, " R10 wrap");
        run(3'd6, 16'h0002, 32'hFFFF_FFFF, 32'hFFFF_FFFF, " R10 wrap");
        run(3'd6, 16'h8000, 32'h0000_4000, 32'h0000_4000, " R10 wrap");
        run(3'd7, 16'hFFFF, 32'hFFFF_FFFF, 32'h1, "");
        run(3'd7, 16'h0000, 32'h0, 32'h0, "");

        // Seeded random mix, back to back (R2)
        for (int i = 0; i < 400; i++) begin
            run(3'($urandom), 16'($urandom), $urandom, $urandom, " R2 rnd");
        end

        // R1: reset in mid-run clears outputs
        mode = 3'd6; cval = 16'h1111; ra = 32'h2222; rb = 32'h3333;
        rst_n = 1'b0;
        @(negedge clk);
        chk_zero("R1 mid");
        rst_n = 1'b1;
        run(3'd6, 16'h1111, 32'h2222, 32'h3333, " after reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule